// File: doc/BRIEF.md
# Banked GPIO Controller with Edge/Level Interrupts and Wake

This block is a memory-mapped general-purpose I/O controller for `NUM_PINS` pins, which must be a multiple of 32. Pins are grouped into 32-bit banks. Every register type has a fixed base word address. The word for bank `b` sits at base + 4·b, and a pin's bit within that word is its index modulo 32. Software drives outputs through separate write-only set and clear words. It chooses per pin whether the pin drives (output enable), and reads back the synchronized pin levels.

Each input passes through a two-flop synchronizer and then a glitch filter, which a per-pin bypass bit can skip. The conditioned value feeds an event detector. In edge mode this detector fires on enabled rising and/or falling transitions. In level mode it fires on every cycle that the pin sits at its programmed active level. Each event sets a per-pin interrupt status bit and a per-pin wake status bit. Both are write-1-to-clear. The status bits are gated by their own masks and ORed into one interrupt line and one wake line.

The register bus is a single-cycle port: address, write strobe, write data, and combinational read data.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Word addresses (hex) are: level 004, direction 01C, set 034, clear 04C, rising enable 064, falling enable 07C, filter bypass 094, interrupt mask 0AC, interrupt status 0C4, type 300, polarity 318, wake mask 400, wake status 418. Bank b of each register is at base + 4·b, and pin p is bit p%32 of bank p/32. Any other address reads zero.
- R2: Writing 1 to a bit of the set word drives that pin's output value high. Writing 1 to a bit of the clear word drives it low. Zero bits change nothing, and both words read zero.
- R3: A direction bit of 1 asserts that pin's `gpio_oe` bit and 0 releases it. The direction word reads back as written.
- R4: The level word returns the pin inputs after a two-flop synchronizer, ahead of the filter. Writes to it change nothing.
- R5: With the type bit 0 (edge mode), a rising transition of the conditioned input sets status when the rising-enable bit is 1. A falling transition sets status when the falling-enable bit is 1. Both may be enabled. With neither enabled, no event occurs.
- R6: With the type bit 1 (level mode), status is set on every cycle in which the conditioned input equals the active level. The active level is high when the polarity bit is 0 and low when it is 1. Clearing the status while that level persists has no lasting effect.
- R7: Writing 1 to an interrupt status bit clears it, and zero bits leave status alone. An event in the same cycle wins over the clear.
- R8: `irq_o` is high exactly when some pin has both its status bit and its interrupt mask bit at 1. Status still records events on masked pins.
- R9: Every event also sets the pin's wake status bit, whatever the wake mask. That bit is write-1-to-clear. `wake_o` is high when some wake status bit and its wake mask bit are both 1.
- R10: With the bypass bit 0, the conditioned input takes a new value only after the synchronized input has differed from it for 3 consecutive clocks, so a 2-clock pulse is dropped. With the bypass bit 1, the synchronized input goes straight to the detector.
- R11: After reset, every direction, output, enable, bypass, type, polarity, mask and status bit is 0. No pin drives, and `irq_o` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register word byte address |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gpio_in | input | NUM_PINS | Raw pin inputs, asynchronous |
| gpio_out | output | NUM_PINS | Output values |
| gpio_oe | output | NUM_PINS | Output enables, 1 = drive |
| irq_o | output | 1 | Combined masked interrupt |
| wake_o | output | 1 | Combined masked wake |

## Verification
The bench feeds the filter a 2-clock pulse and then a 3-clock pulse. A filter with an off-by-one count would pass the first pulse or drop the second. A 1-clock pulse with the bypass set must still register. A level-mode pin is cleared while its level is held, and a controller that treated level pins as latched edges would lose that status bit. Masked pins must still record status without raising `irq_o`, and wake status must collect events before its mask is opened. A second-bank pin is used to catch a bank address or bit slice that is computed wrongly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int AW = 12;

    // word base addresses; software depends on these
    localparam logic [AW-1:0] A_LEVEL = 12'h004;
    localparam logic [AW-1:0] A_DIR   = 12'h01C;
    localparam logic [AW-1:0] A_SET   = 12'h034;
    localparam logic [AW-1:0] A_CLR   = 12'h04C;
    localparam logic [AW-1:0] A_RISE  = 12'h064;
    localparam logic [AW-1:0] A_FALL  = 12'h07C;
    localparam logic [AW-1:0] A_BYP   = 12'h094;
    localparam logic [AW-1:0] A_MASK  = 12'h0AC;
    localparam logic [AW-1:0] A_STAT  = 12'h0C4;
    localparam logic [AW-1:0] A_TYPE  = 12'h300;
    localparam logic [AW-1:0] A_POL   = 12'h318;
    localparam logic [AW-1:0] A_WMASK = 12'h400;
    localparam logic [AW-1:0] A_WSTAT = 12'h418;

    function automatic logic word_hit(input logic [AW-1:0] addr,
                                      input logic [AW-1:0] base,
                                      input int bank);
        return addr == (base + AW'(bank * 4));
    endfunction
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
    parameter int N        = 64,
    parameter int FILT_CYC = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] byp_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] cond_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [N-1:0]         s1;
        logic [N-1:0]         s2;
        logic [N-1:0]         filt;
        logic [N-1:0][CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        for (int i = 0; i < N; i++) begin
            if (st_q.s2[i] == st_q.filt[i]) begin
                st_d.cnt[i] = '0;
            end else if (st_q.cnt[i] == CW'(FILT_CYC - 1)) begin
                st_d.filt[i] = st_q.s2[i];
                st_d.cnt[i]  = '0;
            end else begin
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
    assign cond_o = (byp_i & st_q.s2) | (~byp_i & st_q.filt);

    // the filtered value only moves after a full run of differing samples
    for (genvar g = 0; g < N; g++) begin : g_chk
        a_r10_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(st_q.filt[g]) |-> $past(st_q.cnt[g]) == CW'(FILT_CYC - 1));
    end
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] type_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] rise_en_i,
    input  logic [N-1:0] fall_en_i,
    output logic [N-1:0] evt_o
);
    logic [N-1:0] prev_d, prev_q;
    logic [N-1:0] rose, fell, lvl_act;

    always_comb begin
        prev_d  = cond_i;
        rose    = cond_i & ~prev_q;
        fell    = ~cond_i & prev_q;
        lvl_act = cond_i ^ pol_i;
        evt_o   = (type_i & lvl_act) |
                  (~type_i & ((rose & rise_en_i) | (fell & fall_en_i)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    a_r5_no_enable_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((type_i | rise_en_i | fall_en_i) == '0) |-> (evt_o == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int FILT_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [11:0]         bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] gpio_in,
    output logic [NUM_PINS-1:0] gpio_out,
    output logic [NUM_PINS-1:0] gpio_oe,
    output logic                irq_o,
    output logic                wake_o
);
    localparam int NB = NUM_PINS / 32;

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] outv;
        logic [NUM_PINS-1:0] rise;
        logic [NUM_PINS-1:0] fall;
        logic [NUM_PINS-1:0] byp;
        logic [NUM_PINS-1:0] mask;
        logic [NUM_PINS-1:0] typ;
        logic [NUM_PINS-1:0] pol;
        logic [NUM_PINS-1:0] wmask;
        logic [NUM_PINS-1:0] stat;
        logic [NUM_PINS-1:0] wstat;
    } regs_t;

    regs_t r_d, r_q;
    logic [NUM_PINS-1:0] sync_v, cond_v, evt_v;

    gpio_in_cond #(.N(NUM_PINS), .FILT_CYC(FILT_CYC)) u_cond (
        .clk(clk), .rst_n(rst_n), .pin_i(gpio_in), .byp_i(r_q.byp),
        .sync_o(sync_v), .cond_o(cond_v)
    );

    gpio_evt #(.N(NUM_PINS)) u_evt (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_v), .type_i(r_q.typ),
        .pol_i(r_q.pol), .rise_en_i(r_q.rise), .fall_en_i(r_q.fall),
        .evt_o(evt_v)
    );

    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            for (int b = 0; b < NB; b++) begin
                if (word_hit(bus_addr, A_DIR, b))   r_d.dir[b*32 +: 32]   = bus_wdata;
                if (word_hit(bus_addr, A_SET, b))   r_d.outv[b*32 +: 32]  = r_q.outv[b*32 +: 32] | bus_wdata;
                if (word_hit(bus_addr, A_CLR, b))   r_d.outv[b*32 +: 32]  = r_q.outv[b*32 +: 32] & ~bus_wdata;
                if (word_hit(bus_addr, A_RISE, b))  r_d.rise[b*32 +: 32]  = bus_wdata;
                if (word_hit(bus_addr, A_FALL, b))  r_d.fall[b*32 +: 32]  = bus_wdata;
                if (word_hit(bus_addr, A_BYP, b))   r_d.byp[b*32 +: 32]   = bus_wdata;
                if (word_hit(bus_addr, A_MASK, b))  r_d.mask[b*32 +: 32]  = bus_wdata;
                if (word_hit(bus_addr, A_TYPE, b))  r_d.typ[b*32 +: 32]   = bus_wdata;
                if (word_hit(bus_addr, A_POL, b))   r_d.pol[b*32 +: 32]   = bus_wdata;
                if (word_hit(bus_addr, A_WMASK, b)) r_d.wmask[b*32 +: 32] = bus_wdata;
                if (word_hit(bus_addr, A_STAT, b))  r_d.stat[b*32 +: 32]  = r_q.stat[b*32 +: 32] & ~bus_wdata;
                if (word_hit(bus_addr, A_WSTAT, b)) r_d.wstat[b*32 +: 32] = r_q.wstat[b*32 +: 32] & ~bus_wdata;
            end
        end
        // a new event outranks a clear landing in the same cycle
        r_d.stat  = r_d.stat | evt_v;
        r_d.wstat = r_d.wstat | evt_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (word_hit(bus_addr, A_LEVEL, b)) bus_rdata = sync_v[b*32 +: 32];
            if (word_hit(bus_addr, A_DIR, b))   bus_rdata = r_q.dir[b*32 +: 32];
            if (word_hit(bus_addr, A_RISE, b))  bus_rdata = r_q.rise[b*32 +: 32];
            if (word_hit(bus_addr, A_FALL, b))  bus_rdata = r_q.fall[b*32 +: 32];
            if (word_hit(bus_addr, A_BYP, b))   bus_rdata = r_q.byp[b*32 +: 32];
            if (word_hit(bus_addr, A_MASK, b))  bus_rdata = r_q.mask[b*32 +: 32];
            if (word_hit(bus_addr, A_STAT, b))  bus_rdata = r_q.stat[b*32 +: 32];
            if (word_hit(bus_addr, A_TYPE, b))  bus_rdata = r_q.typ[b*32 +: 32];
            if (word_hit(bus_addr, A_POL, b))   bus_rdata = r_q.pol[b*32 +: 32];
            if (word_hit(bus_addr, A_WMASK, b)) bus_rdata = r_q.wmask[b*32 +: 32];
            if (word_hit(bus_addr, A_WSTAT, b)) bus_rdata = r_q.wstat[b*32 +: 32];
        end
    end

    assign gpio_out = r_q.outv;
    assign gpio_oe  = r_q.dir;
    assign irq_o    = |(r_q.stat & r_q.mask);
    assign wake_o   = |(r_q.wstat & r_q.wmask);

    a_r2_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SET) |=> ((gpio_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    a_r2_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CLR) |=> ((gpio_out[31:0] & $past(bus_wdata)) == '0));

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_STAT && bus_wdata[0] && !evt_v[0]) |=> !r_q.stat[0]);

    a_r6_level_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.typ[0] && (r_q.pol[0] != cond_v[0])) |=> r_q.stat[0]);

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mask == '0) |-> !irq_o);
endmodule

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] gpio_in = '0;
    logic [NP-1:0] gpio_out, gpio_oe;
    logic          irq_o, wake_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq_o(irq_o), .wake_o(wake_o)
    );

    // {address, write data, expected gpio_out}
    localparam logic [107:0] VEC [6] = '{
        {12'h034, 32'h0000_00F0, 64'h0000_0000_0000_00F0},
        {12'h038, 32'h8000_0001, 64'h8000_0001_0000_00F0},
        {12'h04C, 32'h0000_0030, 64'h8000_0001_0000_00C0},
        {12'h04C, 32'h0000_0000, 64'h8000_0001_0000_00C0},
        {12'h050, 32'h0000_0001, 64'h8000_0000_0000_00C0},
        {12'h034, 32'h0000_0003, 64'h8000_0000_0000_00C3}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        settle(3);
        rst_n = 1'b1;
        settle(1);
        // R11 reset state
        chk("R11 gpio_out", gpio_out, '0);
        chk("R11 gpio_oe", gpio_oe, '0);
        chk("R11 irq", {63'd0, irq_o}, 64'd0);
        chk("R11 wake", {63'd0, wake_o}, 64'd0);
        rd(12'h0C4, rv); chk("R11 status", {32'd0, rv}, 64'd0);
        rd(12'h01C, rv); chk("R11 direction", {32'd0, rv}, 64'd0);

        // R2 set/clear table across both banks
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][107:96], VEC[i][95:64]);
            chk("R2 set/clear vector", gpio_out, VEC[i][63:0]);
        end
        rd(12'h034, rv); chk("R2 set reads zero", {32'd0, rv}, 64'd0);
        rd(12'h050, rv); chk("R2 clear reads zero", {32'd0, rv}, 64'd0);

        // R3 direction
        wr(12'h01C, 32'hA5A5_0001);
        wr(12'h020, 32'h0000_8000);
        chk("R3 oe", gpio_oe, 64'h0000_8000_A5A5_0001);
        rd(12'h020, rv); chk("R3 readback", {32'd0, rv}, 64'h8000);

        // R1 unmapped addresses
        rd(12'h000, rv); chk("R1 unmapped 000", {32'd0, rv}, 64'd0);
        rd(12'h200, rv); chk("R1 unmapped 200", {32'd0, rv}, 64'd0);

        // R4 level word, bank 1 at +4; writes ignored
        @(negedge clk); gpio_in = 64'h1234_0000_0000_0500;
        settle(3);
        rd(12'h004, rv); chk("R4 level bank0", {32'd0, rv}, 64'h0000_0500);
        rd(12'h008, rv); chk("R4 level bank1", {32'd0, rv}, 64'h1234_0000);
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, rv); chk("R4 write ignored", {32'd0, rv}, 64'h0000_0500);
        @(negedge clk); gpio_in = '0;
        settle(10);
        wr(12'h0C4, 32'hFFFF_FFFF); wr(12'h418, 32'hFFFF_FFFF);

        // R5 rising edge on pin 3 with bypass, R8 masked combine
        wr(12'h094, 32'h08); wr(12'h064, 32'h08); wr(12'h0AC, 32'h08);
        @(negedge clk); gpio_in[3] = 1'b1;
        settle(5);
        rd(12'h0C4, rv); chk("R5 rise status", {32'd0, rv}, 64'h08);
        chk("R8 irq on", {63'd0, irq_o}, 64'd1);
        wr(12'h0C4, 32'h08);
        rd(12'h0C4, rv); chk("R7 w1c status", {32'd0, rv}, 64'd0);
        chk("R7 irq after clear", {63'd0, irq_o}, 64'd0);

        // R8 masked pin still records status
        wr(12'h0AC, 32'h0);
        @(negedge clk); gpio_in[3] = 1'b0; settle(5);
        @(negedge clk); gpio_in[3] = 1'b1; settle(5);
        rd(12'h0C4, rv); chk("R8 masked status", {32'd0, rv}, 64'h08);
        chk("R8 masked irq low", {63'd0, irq_o}, 64'd0);
        wr(12'h0AC, 32'h08);
        chk("R8 unmask raises", {63'd0, irq_o}, 64'd1);
        wr(12'h0AC, 32'h0); wr(12'h0C4, 32'hFFFF_FFFF);

        // R5 falling only on pin 4, then both edges
        wr(12'h094, 32'h18); wr(12'h064, 32'h0); wr(12'h07C, 32'h10);
        @(negedge clk); gpio_in[4] = 1'b1; settle(5);
        rd(12'h0C4, rv); chk("R5 rise ignored", {32'd0, rv}, 64'd0);
        @(negedge clk); gpio_in[4] = 1'b0; settle(5);
        rd(12'h0C4, rv); chk("R5 fall status", {32'd0, rv}, 64'h10);
        wr(12'h0C4, 32'h10); wr(12'h064, 32'h10);
        @(negedge clk); gpio_in[4] = 1'b1; settle(5);
        rd(12'h0C4, rv); chk("R5 both rise", {32'd0, rv}, 64'h10);
        wr(12'h0C4, 32'h10);
        @(negedge clk); gpio_in[4] = 1'b0; settle(5);
        rd(12'h0C4, rv); chk("R5 both fall", {32'd0, rv}, 64'h10);
        wr(12'h064, 32'h0); wr(12'h07C, 32'h0); wr(12'h0C4, 32'hFFFF_FFFF);

        // R6 level high on pin 5 (filtered path)
        wr(12'h318, 32'h0); wr(12'h300, 32'h20);
        @(negedge clk); gpio_in[5] = 1'b1; settle(10);
        rd(12'h0C4, rv); chk("R6 level high status", {32'd0, rv}, 64'h20);
        wr(12'h0C4, 32'h20);
        rd(12'h0C4, rv); chk("R6 reset while active", {32'd0, rv}, 64'h20);
        @(negedge clk); gpio_in[5] = 1'b0; settle(10);
        wr(12'h0C4, 32'h20);
        rd(12'h0C4, rv); chk("R6 clear after release", {32'd0, rv}, 64'd0);
        // R6 active-low on pin 6 (pin already low)
        wr(12'h318, 32'h40); wr(12'h300, 32'h60);
        settle(2);
        rd(12'h0C4, rv); chk("R6 level low status", {32'd0, rv}, 64'h40);
        wr(12'h300, 32'h0); wr(12'h318, 32'h0); wr(12'h0C4, 32'hFFFF_FFFF);

        // R9 wake on pin 3
        wr(12'h418, 32'hFFFF_FFFF); wr(12'h064, 32'h08);
        @(negedge clk); gpio_in[3] = 1'b0; settle(5);
        @(negedge clk); gpio_in[3] = 1'b1; settle(5);
        rd(12'h418, rv); chk("R9 wake status unmasked", {32'd0, rv}, 64'h08);
        chk("R9 wake low while masked", {63'd0, wake_o}, 64'd0);
        wr(12'h400, 32'h08);
        chk("R9 wake high", {63'd0, wake_o}, 64'd1);
        wr(12'h418, 32'h08);
        chk("R9 wake cleared", {63'd0, wake_o}, 64'd0);
        wr(12'h064, 32'h0); wr(12'h400, 32'h0); wr(12'h0C4, 32'hFFFF_FFFF);

        // R10 filter on pin 7
        wr(12'h094, 32'h0); wr(12'h064, 32'h80);
        @(negedge clk); gpio_in[7] = 1'b1;
        settle(2); gpio_in[7] = 1'b0; settle(10);
        rd(12'h0C4, rv); chk("R10 2-clock pulse dropped", {32'd0, rv}, 64'd0);
        @(negedge clk); gpio_in[7] = 1'b1;
        settle(3); gpio_in[7] = 1'b0; settle(10);
        rd(12'h0C4, rv); chk("R10 3-clock pulse kept", {32'd0, rv}, 64'h80);
        wr(12'h094, 32'h80); wr(12'h0C4, 32'hFFFF_FFFF);
        @(negedge clk); gpio_in[7] = 1'b1;
        settle(1); gpio_in[7] = 1'b0; settle(6);
        rd(12'h0C4, rv); chk("R10 bypass 1-clock pulse", {32'd0, rv}, 64'h80);
        wr(12'h064, 32'h0); wr(12'h0C4, 32'hFFFF_FFFF);

        // R1 bank 1 addressing: pin 40 = bank 1 bit 8
        wr(12'h098, 32'h100); wr(12'h068, 32'h100); wr(12'h0B0, 32'h100);
        @(negedge clk); gpio_in[40] = 1'b1; settle(5);
        rd(12'h0C8, rv); chk("R1 bank1 status", {32'd0, rv}, 64'h100);
        rd(12'h0C4, rv); chk("R1 bank0 untouched", {32'd0, rv}, 64'd0);
        chk("R8 bank1 irq", {63'd0, irq_o}, 64'd1);
        wr(12'h0C8, 32'h100);
        chk("R7 bank1 clear irq", {63'd0, irq_o}, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule